// File: doc/BRIEF.md
# CPU Frame Extraction Word Stream

This block hands frames queued for a processor to software one 32-bit word per read. A producer pushes frame bytes with start, end and abort flags. The block packs them into words and keeps them in a small word FIFO. On the processor side the current word is always visible on a read-data port, and a read strobe takes it. The first words of each frame are the internal header that the producer writes in front of the frame data, which ends with the 4-byte FCS. The block passes those header words through as ordinary data words.

Control information travels in the same word stream as reserved codes. Each code has 0x80 in bits 7:0, zeros in bits 23:8 and 31:27, and a 3-bit number in bits 26:24. Code numbers 0 to 3 close a frame, 4 closes a frame that was cut short, 5 reports a frame abandoned by the producer, 6 is an escape prefix, and 7 means no word is waiting. A data word that happens to equal a reserved code is sent as the escape code followed by the raw word. Software can therefore always tell data from control.

Top module: `cpu_xtr_stream`

## Requirements
- R1: When no word is waiting, rd_data reads 0x07000080, and a read strobe in that state consumes nothing: the next queued word is still returned afterwards.
- R2: A frame's bytes come out in arrival order, packed four to a word with the earliest byte in bits 31:24 (byte swap off). Every word except the last is sent as a plain data word.
- R3: The last word of a frame is announced by the code 0x0N000080, where N = 4 minus the number of valid bytes in that word. The code is followed by that word, with its valid bytes in the top positions and zeros below them. A one-byte frame therefore gives 0x03000080 and then 0xBB000000.
- R4: Any data word or final word equal to a reserved value (low byte 0x80, bits 31:27 and 23:8 zero) is preceded by the escape word 0x06000080 and is then sent unchanged.
- R5: An abort flag during a frame drops the partly packed word and queues the code 0x05000080 after the frame's earlier words. An abort flag outside a frame queues nothing.
- R6: A frame longer than MAX_WORDS*4 bytes is cut. After MAX_WORDS-1 data words come the code 0x04000080 and then word number MAX_WORDS with all 4 bytes. The frame's remaining bytes, up to its end flag, are dropped.
- R7: data_present is high exactly while at least one word of a queued entry, including its code, escape and final words, is still unread.
- R8: With swap_en high, the bytes of data words and final words are reversed, and the escape decision is taken on the reversed word. Reserved codes are never reversed.
- R9: A flush cycle discards every queued word and any partly packed frame, and data_present is low after that edge. Bytes offered during flush are accepted and dropped.
- R10: Bytes that arrive outside a frame are dropped. A frame begins only with a byte that has in_sof set, and this includes the bytes that follow a flush.
- R11: in_ready is low while the word FIFO holds FIFO_DEPTH entries (unless flushing), so that no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer byte valid |
| in_data | input | 8 | Producer byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_abort | input | 1 | Abandon the current frame (byte value ignored) |
| in_ready | output | 1 | Block can take a byte this cycle |
| rd_en | input | 1 | Processor read strobe, consumes rd_data |
| rd_data | output | 32 | Word a read returns |
| data_present | output | 1 | A word is waiting to be read |
| swap_en | input | 1 | Reverse bytes of data words |
| flush | input | 1 | Discard all queued and partial data |

## Verification
The embedded properties check, on every cycle, that an empty queue reads as the not-ready code, that an idle read changes no FIFO occupancy, and that an escape or end code is always followed by a still-waiting word. They also check that flush empties the queue, that the FIFO never overflows or underflows, and that packing never passes the frame word limit. Only the bench's scenarios can show that the words carry the right content: byte order and swapping, the end-code number for each final-word length, escaping of colliding data and final words, truncation of long frames, dropping of bytes outside a frame, and backpressure while the queue is full.

// File: rtl/cxs_pkg.sv
package cxs_pkg;

  typedef enum logic [1:0] {EK_DATA, EK_LAST, EK_PRUNE, EK_ABORT} ent_kind_e;

  typedef struct packed {
    ent_kind_e   kind;
    logic [2:0]  nbytes;
    logic [31:0] word;
  } ent_t;

  localparam logic [2:0] CN_PRUNE = 3'd4;
  localparam logic [2:0] CN_ABORT = 3'd5;
  localparam logic [2:0] CN_ESC   = 3'd6;
  localparam logic [2:0] CN_IDLE  = 3'd7;

  function automatic logic [31:0] ctl_word(input logic [2:0] num);
    return {5'd0, num, 16'd0, 8'h80};
  endfunction

  function automatic logic is_ctl(input logic [31:0] w);
    return (w[7:0] == 8'h80) && (w[23:8] == 16'd0) && (w[31:27] == 5'd0);
  endfunction

  function automatic logic [31:0] rev_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // end-of-frame code number from count of valid bytes (1..4)
  function automatic logic [2:0] eof_num(input logic [2:0] nb);
    return 3'd4 - nb;
  endfunction

  // place a byte into slot idx, slot 0 being bits 31:24
  function automatic logic [31:0] put_byte(input logic [31:0] base,
                                           input logic [1:0] idx,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = base;
    case (idx)
      2'd0: r[31:24] = b;
      2'd1: r[23:16] = b;
      2'd2: r[15:8]  = b;
      default: r[7:0] = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cxs_packer.sv
module cxs_packer
  import cxs_pkg::*;
#(
  parameter int MAX_WORDS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_abort,
  input  logic       in_ready,
  output logic       push,
  output ent_t       push_ent
);
  localparam int WCW = $clog2(MAX_WORDS + 1);

  typedef enum logic [1:0] {PK_WAIT, PK_FILL, PK_DROP} pk_e;

  pk_e            st_q;
  logic [31:0]    acc_q;
  logic [1:0]     bcnt_q;
  logic [WCW-1:0] wcnt_q;

  logic           take, start, fbyte, wdone, abort_push, last_slot, ev_prune;
  logic [1:0]     cur_b;
  logic [WCW-1:0] cur_w;
  logic [31:0]    word_now;

  assign take       = in_valid && in_ready && !flush;
  assign start      = take && (st_q == PK_WAIT) && in_sof && !in_abort;
  assign fbyte      = take && !in_abort && ((st_q == PK_FILL) || start);
  assign cur_b      = start ? 2'd0 : bcnt_q;
  assign cur_w      = start ? '0 : wcnt_q;
  assign word_now   = put_byte(start ? 32'd0 : acc_q, cur_b, in_data);
  assign last_slot  = (cur_w == WCW'(MAX_WORDS - 1));
  assign wdone      = fbyte && ((cur_b == 2'd3) || in_eof);
  assign abort_push = take && in_abort && (st_q == PK_FILL);
  assign ev_prune   = wdone && !in_eof && last_slot;
  assign push       = wdone || abort_push;

  always_comb begin
    push_ent = '0;
    if (abort_push) begin
      push_ent.kind   = EK_ABORT;
      push_ent.nbytes = 3'd0;
      push_ent.word   = 32'd0;
    end else if (in_eof) begin
      push_ent.kind   = EK_LAST;
      push_ent.nbytes = {1'b0, cur_b} + 3'd1;
      push_ent.word   = word_now;
    end else begin
      push_ent.kind   = last_slot ? EK_PRUNE : EK_DATA;
      push_ent.nbytes = 3'd4;
      push_ent.word   = word_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      st_q   <= PK_WAIT;
      acc_q  <= '0;
      bcnt_q <= '0;
      wcnt_q <= '0;
    end else if (take && in_abort) begin
      st_q <= PK_WAIT;
    end else if (fbyte) begin
      if (wdone) begin
        acc_q  <= '0;
        bcnt_q <= '0;
        wcnt_q <= cur_w + 1'b1;
        st_q   <= in_eof ? PK_WAIT : (ev_prune ? PK_DROP : PK_FILL);
      end else begin
        acc_q  <= word_now;
        bcnt_q <= cur_b + 2'd1;
        wcnt_q <= cur_w;
        st_q   <= PK_FILL;
      end
    end else if (take && (st_q == PK_DROP) && in_eof) begin
      st_q <= PK_WAIT;
    end
  end

  p_frame_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PK_FILL) |-> (wcnt_q < WCW'(MAX_WORDS)));

  p_prune_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prune |=> (st_q == PK_DROP) || $past(flush));

endmodule

// File: rtl/cxs_fifo.sv
module cxs_fifo
  import cxs_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  ent_t                         wdata,
  input  logic                         pop,
  output ent_t                         rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ent_t          mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign fill    = cnt_q;
  assign rdata   = mem[rp_q];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= ptr_inc(wp_q);
      if (do_pop)  rp_q <= ptr_inc(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush) |-> !push);

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

endmodule

// File: rtl/cxs_reader.sv
module cxs_reader
  import cxs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        swap_en,
  input  logic        rd_en,
  input  ent_t        head,
  input  logic        present,
  output logic        pop,
  output logic [31:0] rd_data,
  output logic        ev_escape,
  output logic        ev_code
);
  typedef enum logic [1:0] {RS_HEAD, RS_TAIL, RS_RAW} rs_e;

  rs_e         st_q, st_d;
  logic [31:0] body;
  logic        take;

  assign body = swap_en ? rev_bytes(head.word) : head.word;
  assign take = rd_en && !flush;

  always_comb begin
    rd_data   = ctl_word(CN_IDLE);
    pop       = 1'b0;
    st_d      = st_q;
    ev_escape = 1'b0;
    ev_code   = 1'b0;
    if (present) begin
      if (st_q == RS_RAW) begin
        rd_data = body;
        pop     = take;
      end else if (st_q == RS_HEAD && head.kind == EK_ABORT) begin
        rd_data = ctl_word(CN_ABORT);
        pop     = take;
      end else if (st_q == RS_HEAD && head.kind == EK_LAST) begin
        rd_data = ctl_word(eof_num(head.nbytes));
        ev_code = 1'b1;
        if (take) st_d = RS_TAIL;
      end else if (st_q == RS_HEAD && head.kind == EK_PRUNE) begin
        rd_data = ctl_word(CN_PRUNE);
        ev_code = 1'b1;
        if (take) st_d = RS_TAIL;
      end else if (is_ctl(body)) begin
        rd_data   = ctl_word(CN_ESC);
        ev_escape = 1'b1;
        if (take) st_d = RS_RAW;
      end else begin
        rd_data = body;
        pop     = take;
      end
    end
    if (pop) st_d = RS_HEAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) st_q <= RS_HEAD;
    else                 st_q <= st_d;
  end

  p_notready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !present |-> (rd_data == 32'h07000080));

  p_escape_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !flush && ev_escape) |=> (present && is_ctl(rd_data)));

  p_code_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !flush && ev_code) |=> present);

endmodule

// File: rtl/cpu_xtr_stream.sv
module cpu_xtr_stream
  import cxs_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int MAX_WORDS  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_abort,
  output logic        in_ready,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        data_present,
  input  logic        swap_en,
  input  logic        flush
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic          push, pop, full, empty, ev_escape, ev_code;
  ent_t          push_ent, head;
  logic [CW-1:0] fill;

  assign in_ready     = !full || flush;
  assign data_present = !empty;

  cxs_packer #(.MAX_WORDS(MAX_WORDS)) u_pack (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_abort(in_abort), .in_ready(in_ready),
    .push(push), .push_ent(push_ent)
  );

  cxs_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(push), .wdata(push_ent), .pop(pop), .rdata(head),
    .full(full), .empty(empty), .fill(fill)
  );

  cxs_reader u_rd (
    .clk(clk), .rst_n(rst_n), .flush(flush), .swap_en(swap_en),
    .rd_en(rd_en), .head(head), .present(!empty), .pop(pop),
    .rd_data(rd_data), .ev_escape(ev_escape), .ev_code(ev_code)
  );

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !data_present);

  p_idle_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !data_present && !flush) |=>
      (fill == $past(fill) + CW'($past(push))));

endmodule

// File: tb/cpu_xtr_stream_test.sv
module cpu_xtr_stream_test;
  localparam int DEPTH = 8;
  localparam int MAXW  = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 0, in_sof = 0, in_eof = 0, in_abort = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready, rd_en = 0, data_present, swap_en = 0, flush = 0;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  cpu_xtr_stream #(.FIFO_DEPTH(DEPTH), .MAX_WORDS(MAXW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_abort(in_abort), .in_ready(in_ready),
    .rd_en(rd_en), .rd_data(rd_data), .data_present(data_present),
    .swap_en(swap_en), .flush(flush)
  );

  int n_chk = 0, n_bad = 0, rd_mode = 0;
  string cur_req = "R1";
  bit last_acc;
  logic [32:0] m_q[$];
  logic [31:0] got[$];
  int m_st = 0, m_n = 0, m_wc = 0, m_ent = 0;
  logic [31:0] m_w = 0;

  function automatic logic [31:0] flip(input logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = w[8*(3-i) +: 8];
    return r;
  endfunction

  function automatic bit reserved(input logic [31:0] w);
    return (w & 32'hF8FFFFFF) == 32'h00000080;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic m_put(input logic [31:0] raw);
    logic [31:0] w;
    w = swap_en ? flip(raw) : raw;
    if (reserved(w)) m_q.push_back({1'b0, 32'h06000080});
    m_q.push_back({1'b1, w});
  endtask

  task automatic m_take(input logic [7:0] b, input logic eof);
    m_w = {m_w[23:0], b};
    m_n++;
    if (eof) begin
      m_ent++;
      m_q.push_back({1'b0, (32'(4 - m_n) << 24) | 32'h80});
      m_put(m_w << (8 * (4 - m_n)));
      m_st = 0;
    end else if (m_n == 4) begin
      m_ent++;
      if (m_wc == MAXW - 1) begin
        m_q.push_back({1'b0, 32'h04000080});
        m_st = 2;
      end
      m_put(m_w);
      m_wc++;
      m_w = 0;
      m_n = 0;
    end
  endtask

  task automatic step();
    logic [32:0] e;
    rd_en = (rd_mode == 1);
    last_acc = in_valid && in_ready;
    if (rd_en && data_present) got.push_back(rd_data);
    if (rst_n) begin
      if (flush) begin
        m_q.delete(); m_ent = 0; m_st = 0;
      end else begin
        if (rd_en && m_q.size() != 0) begin
          e = m_q.pop_front();
          if (e[32]) m_ent--;
        end
        if (last_acc) begin
          if (in_abort) begin
            if (m_st == 1) begin m_ent++; m_q.push_back({1'b1, 32'h05000080}); end
            m_st = 0;
          end else if (m_st == 0) begin
            if (in_sof) begin
              m_st = 1; m_w = 0; m_n = 0; m_wc = 0;
              m_take(in_data, in_eof);
            end
          end else if (m_st == 1) begin
            m_take(in_data, in_eof);
          end else if (in_eof) begin
            m_st = 0;
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(cur_req, rd_data, (m_q.size() != 0) ? m_q[0][31:0] : 32'h07000080, "rd_data");
    check(cur_req, {31'd0, data_present}, {31'd0, m_q.size() != 0}, "data_present (R7)");
    check(cur_req, {31'd0, in_ready}, {31'd0, (m_ent < DEPTH) || flush}, "in_ready (R11)");
  endtask

  task automatic sb(input logic [7:0] b, input logic sof, input logic eof,
                    input logic ab = 1'b0);
    in_valid = 1; in_data = b; in_sof = sof; in_eof = eof; in_abort = ab;
    for (int i = 0; i < 500; i++) begin
      step();
      if (last_acc) break;
    end
    in_valid = 0; in_sof = 0; in_eof = 0; in_abort = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    rd_mode = 1;
    for (int i = 0; i < 400 && m_q.size() != 0; i++) step();
    rd_mode = 0;
    step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(2);
    rst_n = 1;
    idle(1);
    // R1 / R7 reset state
    check("R1", rd_data, 32'h07000080, "reset rd_data");
    check("R7", {31'd0, data_present}, 32'd0, "reset data_present");

    // R1: idle read consumes nothing
    cur_req = "R1";
    rd_mode = 1; idle(3); rd_mode = 0;
    check("R1", rd_data, 32'h07000080, "idle read");

    // R2 / R3: 10-byte frame
    cur_req = "R2"; got.delete();
    for (int i = 0; i < 10; i++) sb(8'(8'h11 + i), i == 0, i == 9);
    drain();
    check("R2", got[0], 32'h11121314, "word0");
    check("R2", got[1], 32'h15161718, "word1");
    check("R3", got[2], 32'h02000080, "eof code 2 bytes");
    check("R3", got[3], 32'h191A0000, "final word");

    // R3: one-byte frame
    cur_req = "R3"; got.delete();
    sb(8'hBB, 1, 1);
    drain();
    check("R3", got[0], 32'h03000080, "eof code 1 byte");
    check("R3", got[1], 32'hBB000000, "single final");

    // R4: colliding data and final words
    cur_req = "R4"; got.delete();
    sb(8'h04, 1, 0); sb(8'h00, 0, 0); sb(8'h00, 0, 0); sb(8'h80, 0, 0);
    sb(8'hAA, 0, 0); sb(8'hBB, 0, 0); sb(8'hCC, 0, 0); sb(8'hDD, 0, 0);
    sb(8'h03, 0, 0); sb(8'h00, 0, 0); sb(8'h00, 0, 0); sb(8'h80, 0, 1);
    drain();
    check("R4", got[0], 32'h06000080, "escape before data");
    check("R4", got[1], 32'h04000080, "raw data");
    check("R4", got[3], 32'h00000080, "eof code 4 bytes");
    check("R4", got[4], 32'h06000080, "escape before final");
    check("R4", got[5], 32'h03000080, "raw final");

    // R5: abort mid-frame, then abort outside frame
    cur_req = "R5"; got.delete();
    for (int i = 0; i < 10; i++) sb(8'(8'h40 + i), i == 0, 0);
    sb(8'h00, 0, 0, 1);
    drain();
    check("R5", got.size(), 3, "abort read count");
    check("R5", got[2], 32'h05000080, "abort code");
    sb(8'h00, 0, 0, 1);
    idle(2);
    check("R5", {31'd0, data_present}, 32'd0, "abort outside frame");

    // R6: long frame is cut
    cur_req = "R6"; got.delete();
    rd_mode = 1;
    for (int i = 0; i < MAXW * 4 + 5; i++) sb(8'(i), i == 0, i == MAXW * 4 + 4);
    drain();
    check("R6", got.size(), MAXW + 1, "pruned read count");
    check("R6", got[MAXW - 1], 32'h04000080, "prune code");
    check("R6", got[MAXW], 32'h3C3D3E3F, "last kept word");

    // R8: byte swap
    cur_req = "R8"; got.delete();
    swap_en = 1;
    sb(8'h80, 1, 0); sb(8'h00, 0, 0); sb(8'h00, 0, 0); sb(8'h05, 0, 0);
    sb(8'h01, 0, 0); sb(8'h02, 0, 0); sb(8'h03, 0, 0); sb(8'h04, 0, 1);
    drain();
    check("R8", got[0], 32'h06000080, "escape after swap");
    check("R8", got[1], 32'h05000080, "swapped raw");
    check("R8", got[2], 32'h00000080, "code not swapped");
    check("R8", got[3], 32'h04030201, "swapped final");
    swap_en = 0;
    idle(1);

    // R9: flush; R10: bytes without start dropped
    cur_req = "R9";
    for (int i = 0; i < 6; i++) sb(8'(8'h60 + i), i == 0, 0);
    check("R9", {31'd0, data_present}, 32'd1, "present before flush");
    flush = 1; step(); flush = 0;
    check("R9", {31'd0, data_present}, 32'd0, "present after flush");
    check("R9", rd_data, 32'h07000080, "not-ready after flush");
    cur_req = "R10";
    for (int i = 0; i < 4; i++) sb(8'(8'h70 + i), 0, i == 3);
    idle(1);
    check("R10", {31'd0, data_present}, 32'd0, "bytes outside frame");
    got.delete();
    sb(8'h71, 1, 0); sb(8'h72, 0, 1);
    drain();
    check("R10", got[0], 32'h02000080, "frame after flush code");
    check("R10", got[1], 32'h71720000, "frame after flush word");

    // R11: backpressure when full
    cur_req = "R11"; got.delete();
    for (int i = 0; i < DEPTH * 4; i++) sb(8'(8'h20 + i), i == 0, 0);
    idle(1);
    check("R11", {31'd0, in_ready}, 32'd0, "in_ready when full");
    rd_mode = 1;
    for (int i = 0; i < 3; i++) sb(8'(8'h50 + i), 0, i == 2);
    drain();
    check("R11", got.size(), DEPTH + 2, "no word lost");
    check("R11", got[DEPTH], 32'h01000080, "eof code 3 bytes");
    check("R11", got[DEPTH + 1], 32'h50515200, "final after backpressure");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule